// File: doc/BRIEF.md
# Synthesizer Divisor Search Engine

This block picks divider settings for a clock synthesizer that runs from a fixed 96000 kHz reference. Given a requested dot clock in kHz, it walks every allowed combination of the input divider N, the two feedback dividers M1 and M2, and the post divider P1. For each one it works out the frequency the synthesizer would produce, and it keeps the combination that lands closest to the request. The second post divider P2 is not searched. It is fixed from the size of the request before the walk starts.

A controller pulses `start` with the target on `target_khz`. It then waits for the one-cycle `done` pulse and reads the chosen dividers, the absolute error and a found flag. It also gets two ready-made fields: the three dividers packed into one word, and P1 expressed as a one-hot mask. A single restoring divider is shared by both rounded divisions. The synthesizer frequency is computed once for each (N, M1, M2) triple and reused across the P1 values of that triple.

Top module: `pll_div_search`

## Requirements
- R1: After reset, `busy` and `done` are 0 and every result output (`found`, dividers, `p2_sel`, `err_khz`, `fp_word`, `p1_onehot`) is 0.
- R2: A `start` seen while idle raises `busy` on the next cycle. `busy` stays high until the search ends. At the end, `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R3: `p2_sel` is 10 when the target is at most 225000 kHz and 5 when it is above.
- R4: The reported error equals |dot − target|, where M = 5·(M1+2)+(M2+2), P = P1·P2, vco = floor((96000·M + floor((N+2)/2)) / (N+2)) and dot = floor((vco + floor(P/2)) / P). No candidate in the search space has a smaller error.
- R5: Candidates are visited with N rising from 1 to 4 as the outermost loop, then M1 falling from 23 to 16, then M2 falling from 11 to 5, then P1 falling from 8 to 1 as the innermost loop. A later candidate replaces the best one only if its error is strictly smaller, so on a tie the earliest candidate wins.
- R6: `found` is 1 exactly when the final best error is below 0xFFFFFFFF. The best error starts the search at 0xFFFFFFFF.
- R7: `fp_word` holds N in bits 23:16, M1 in bits 15:8 and M2 in bits 7:0, with bits 31:24 at zero.
- R8: `p1_onehot` has exactly one bit set after a search, at position P1−1.
- R9: A `start` received while `busy` is high is ignored. The running search keeps the target latched at its own start, and only one `done` is produced.
- R10: Result outputs change only in the cycle `done` is high. They keep their values while idle and during the whole of a following search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (taken only when idle) |
| target_khz | input | DW | Requested dot clock in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| found | output | 1 | A candidate beat the initial error |
| n_sel | output | 8 | Chosen N |
| m1_sel | output | 8 | Chosen M1 |
| m2_sel | output | 8 | Chosen M2 |
| p1_sel | output | 8 | Chosen P1 |
| p2_sel | output | 4 | Chosen P2 (10 or 5) |
| err_khz | output | DW | Absolute error of the chosen candidate |
| fp_word | output | 32 | Packed N/M1/M2 word |
| p1_onehot | output | P1_FIRST | One-hot P1 mask |

## Verification
The bench builds two copies of the block. The main copy uses shrunken divider ranges: N 1..2, M1 17..16, M2 6..5 and P1 3..1, which gives 24 candidates. With so few candidates each search is short, so dozens of targets can be compared against an arithmetic model. These targets include every exact candidate frequency, midpoints between neighbouring candidates that force ties, both sides of the 225000 kHz P2 boundary, and zero. A second copy with the default full ranges runs one 25175 kHz search alongside, so the complete 1792-candidate order and the wide dividers are also covered.

// File: rtl/pll_div_search.sv
module pll_div_search #(
  parameter int unsigned REF_KHZ      = 96000,
  parameter int unsigned P2_SPLIT_KHZ = 225000,
  parameter int unsigned P2_SLOW      = 10,
  parameter int unsigned P2_FAST      = 5,
  parameter int unsigned N_FIRST      = 1,
  parameter int unsigned N_LAST       = 4,
  parameter int unsigned M1_FIRST     = 23,
  parameter int unsigned M1_LAST      = 16,
  parameter int unsigned M2_FIRST     = 11,
  parameter int unsigned M2_LAST      = 5,
  parameter int unsigned P1_FIRST     = 8,
  parameter int unsigned P1_LAST      = 1,
  parameter int unsigned DW           = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [DW-1:0]       target_khz,
  output logic                busy,
  output logic                done,
  output logic                found,
  output logic [7:0]          n_sel,
  output logic [7:0]          m1_sel,
  output logic [7:0]          m2_sel,
  output logic [7:0]          p1_sel,
  output logic [3:0]          p2_sel,
  output logic [DW-1:0]       err_khz,
  output logic [31:0]         fp_word,
  output logic [P1_FIRST-1:0] p1_onehot
);
  localparam int unsigned IW  = 8;
  localparam int unsigned P1W = P1_FIRST;
  localparam int unsigned CW  = $clog2(DW);

  typedef enum logic [2:0] {S_IDLE, S_VLOAD, S_VDIV, S_DLOAD, S_DDIV, S_CMP} st_t;
  st_t st;

  logic [DW-1:0] tgt, vco, dot, best_err;
  logic [3:0]    p2w;
  logic [IW-1:0] n, m1, m2, p1, bn, bm1, bm2, bp1;
  logic [DW-1:0] dq, dr, dd;
  logic [CW-1:0] cnt;
  logic          ok;

  logic [DW-1:0] mul_w, ndiv, pdiv, cand_err, rem_nx, q_nx, fin_err;
  logic [DW:0]   shifted;
  logic          ge, win, last_p1, last_m2, last_m1, last_n;

  assign mul_w   = DW'(32'd5 * (32'(m1) + 32'd2) + 32'(m2) + 32'd2);
  assign ndiv    = DW'(n) + DW'(2);
  assign pdiv    = DW'(p1) * DW'(p2w);
  assign shifted = {dr, dq[DW-1]};
  assign ge      = shifted >= {1'b0, dd};
  assign rem_nx  = ge ? DW'(shifted - {1'b0, dd}) : DW'(shifted);
  assign q_nx    = {dq[DW-2:0], ge};

  assign cand_err = (dot > tgt) ? dot - tgt : tgt - dot;
  assign win      = cand_err < best_err;
  assign fin_err  = win ? cand_err : best_err;
  assign last_p1  = p1 == IW'(P1_LAST);
  assign last_m2  = m2 == IW'(M2_LAST);
  assign last_m1  = m1 == IW'(M1_LAST);
  assign last_n   = n  == IW'(N_LAST);

  assign busy      = st != S_IDLE;
  assign fp_word   = {8'd0, n_sel, m1_sel, m2_sel};
  assign p1_onehot = (p1_sel == '0) ? '0 : (P1W'(1) << (p1_sel - 8'd1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      tgt <= '0; vco <= '0; dot <= '0; best_err <= '1; p2w <= '0;
      n <= '0; m1 <= '0; m2 <= '0; p1 <= '0;
      bn <= '0; bm1 <= '0; bm2 <= '0; bp1 <= '0;
      dq <= '0; dr <= '0; dd <= '0; cnt <= '0;
      done <= 1'b0; found <= 1'b0; err_khz <= '0;
      n_sel <= '0; m1_sel <= '0; m2_sel <= '0; p1_sel <= '0; p2_sel <= '0;
      ok <= 1'b0;
    end else begin
      ok   <= 1'b1;
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          tgt      <= target_khz;
          p2w      <= (target_khz <= DW'(P2_SPLIT_KHZ)) ? 4'(P2_SLOW) : 4'(P2_FAST);
          n        <= IW'(N_FIRST);
          m1       <= IW'(M1_FIRST);
          m2       <= IW'(M2_FIRST);
          p1       <= IW'(P1_FIRST);
          best_err <= '1;
          st       <= S_VLOAD;
        end
        S_VLOAD: begin
          dq  <= DW'(REF_KHZ) * mul_w + (ndiv >> 1);
          dd  <= ndiv;
          dr  <= '0;
          cnt <= '0;
          st  <= S_VDIV;
        end
        S_VDIV: begin
          dq  <= q_nx;
          dr  <= rem_nx;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(DW-1)) begin
            vco <= q_nx;
            st  <= S_DLOAD;
          end
        end
        S_DLOAD: begin
          dq  <= vco + (pdiv >> 1);
          dd  <= pdiv;
          dr  <= '0;
          cnt <= '0;
          st  <= S_DDIV;
        end
        S_DDIV: begin
          dq  <= q_nx;
          dr  <= rem_nx;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(DW-1)) begin
            dot <= q_nx;
            st  <= S_CMP;
          end
        end
        S_CMP: begin
          if (win) begin
            best_err <= cand_err;
            bn <= n; bm1 <= m1; bm2 <= m2; bp1 <= p1;
          end
          if (!last_p1) begin
            p1 <= p1 - 1'b1;
            st <= S_DLOAD;
          end else begin
            p1 <= IW'(P1_FIRST);
            st <= S_VLOAD;
            if (!last_m2) m2 <= m2 - 1'b1;
            else begin
              m2 <= IW'(M2_FIRST);
              if (!last_m1) m1 <= m1 - 1'b1;
              else begin
                m1 <= IW'(M1_FIRST);
                if (!last_n) n <= n + 1'b1;
                else begin
                  st      <= S_IDLE;
                  done    <= 1'b1;
                  err_khz <= fin_err;
                  found   <= fin_err != '1;
                  n_sel   <= win ? n  : bn;
                  m1_sel  <= win ? m1 : bm1;
                  m2_sel  <= win ? m2 : bm2;
                  p1_sel  <= win ? p1 : bp1;
                  p2_sel  <= p2w;
                end
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_tgt_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && busy && $past(busy)) |-> $stable(tgt));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && !done) |-> ($stable(err_khz) && $stable(fp_word) && $stable(p1_sel)));
  p_best_mono_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && busy && $past(busy)) |-> (best_err <= $past(best_err)));
  p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (n >= IW'(N_FIRST) && n <= IW'(N_LAST) &&
              p1 >= IW'(P1_LAST) && p1 <= IW'(P1_FIRST)));
  p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ($countones(p1_onehot) == 1));
endmodule

// File: tb/pll_div_search_test.sv
`timescale 1ns/1ps
module pll_div_search_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic start_s = 1'b0, start_f = 1'b0;
  logic [31:0] tgt_s = '0, tgt_f = '0;
  logic busy_s, done_s, found_s, busy_f, done_f, found_f;
  logic [7:0] n_s, m1_s, m2_s, p1_s, n_f, m1_f, m2_f, p1_f;
  logic [3:0] p2_s, p2_f;
  logic [31:0] err_s, err_f, fp_s, fp_f;
  logic [2:0] oh_s;
  logic [7:0] oh_f;

  pll_div_search #(.N_FIRST(1), .N_LAST(2), .M1_FIRST(17), .M1_LAST(16),
                   .M2_FIRST(6), .M2_LAST(5), .P1_FIRST(3), .P1_LAST(1)) uut (
    .clk(clk), .rst_n(rst_n), .start(start_s), .target_khz(tgt_s),
    .busy(busy_s), .done(done_s), .found(found_s), .n_sel(n_s), .m1_sel(m1_s),
    .m2_sel(m2_s), .p1_sel(p1_s), .p2_sel(p2_s), .err_khz(err_s),
    .fp_word(fp_s), .p1_onehot(oh_s));

  pll_div_search uut_full (
    .clk(clk), .rst_n(rst_n), .start(start_f), .target_khz(tgt_f),
    .busy(busy_f), .done(done_f), .found(found_f), .n_sel(n_f), .m1_sel(m1_f),
    .m2_sel(m2_f), .p1_sel(p1_f), .p2_sel(p2_f), .err_khz(err_f),
    .fp_word(fp_f), .p1_onehot(oh_f));

  int checks = 0, fails = 0;
  int dones_s = 0, pulse_bad = 0;
  logic done_prev = 1'b0;
  bit finished = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (done_s) dones_s++;
      if (done_s && done_prev) pulse_bad++;
    end
    done_prev <= done_s;
  end

  task automatic chk(input string req, input longint unsigned got, input longint unsigned exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic model(input longint unsigned t, input int nf, nl, m1f, m1l, m2f, m2l, p1f, p1l,
                       output int bn, bm1, bm2, bp1, bp2, output longint unsigned berr);
    longint unsigned m, vco, p, dot, e;
    bp2 = (t <= 225000) ? 10 : 5;
    berr = 64'hFFFF_FFFF;
    bn = 0; bm1 = 0; bm2 = 0; bp1 = 0;
    for (int n = nf; n <= nl; n++)
      for (int a = m1f; a >= m1l; a--)
        for (int b = m2f; b >= m2l; b--)
          for (int c = p1f; c >= p1l; c--) begin
            m = 5 * (a + 2) + (b + 2);
            vco = (96000 * m + (n + 2) / 2) / (n + 2);
            p = c * bp2;
            dot = (vco + p / 2) / p;
            e = (dot > t) ? dot - t : t - dot;
            if (e < berr) begin
              berr = e; bn = n; bm1 = a; bm2 = b; bp1 = c;
            end
          end
  endtask

  task automatic wait_done_s();
    for (int k = 0; k < 100000 && !done_s; k++) @(negedge clk);
  endtask

  task automatic run_small(input longint unsigned t);
    int en, em1, em2, ep1, ep2;
    longint unsigned ee;
    @(negedge clk);
    start_s = 1'b1; tgt_s = 32'(t);
    @(negedge clk);
    start_s = 1'b0;
    chk("R2 busy after start", busy_s, 1);
    wait_done_s();
    chk("R2 done seen", done_s, 1);
    chk("R2 busy low at done", busy_s, 0);
    model(t, 1, 2, 17, 16, 6, 5, 3, 1, en, em1, em2, ep1, ep2, ee);
    chk("R4 error", err_s, ee);
    chk("R5 n", n_s, en);
    chk("R5 m1", m1_s, em1);
    chk("R5 m2", m2_s, em2);
    chk("R5 p1", p1_s, ep1);
    chk("R3 p2", p2_s, ep2);
    chk("R6 found", found_s, (ee < 64'hFFFF_FFFF) ? 1 : 0);
    chk("R7 packed", fp_s, (en << 16) | (em1 << 8) | em2);
    chk("R8 onehot", oh_s, 1 << (ep1 - 1));
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  longint unsigned dots[24];

  task automatic small_seq();
    int idx, en, em1, em2, ep1, ep2, base_dn;
    longint unsigned ee, m, vco, p;
    logic [31:0] h_err, h_fp;
    logic [7:0] h_p1;
    idx = 0;
    for (int n = 1; n <= 2; n++)
      for (int a = 17; a >= 16; a--)
        for (int b = 6; b >= 5; b--)
          for (int c = 3; c >= 1; c--) begin
            m = 5 * (a + 2) + (b + 2);
            vco = (96000 * m + (n + 2) / 2) / (n + 2);
            p = c * 10;
            dots[idx] = (vco + p / 2) / p;
            idx++;
          end
    run_small(25175);
    run_small(0);
    run_small(1);
    run_small(65000);
    run_small(108000);
    run_small(225000);
    run_small(225001);
    run_small(300000);
    run_small(660000);
    run_small(32'hFFFF_FFFF);
    for (int i = 0; i < 24; i++) begin
      if (dots[i] <= 225000) run_small(dots[i]);
    end
    // R5 tie cases: midpoints between neighbouring candidates
    for (int i = 0; i < 23; i++) begin
      if (dots[i] != dots[i+1] && ((dots[i] + dots[i+1]) % 2 == 0) &&
          (dots[i] + dots[i+1]) / 2 <= 225000)
        run_small((dots[i] + dots[i+1]) / 2);
    end

    // R10: outputs hold while idle with changing target
    h_err = err_s; h_fp = fp_s; h_p1 = p1_s;
    tgt_s = 32'd150000;
    repeat (20) @(negedge clk);
    chk("R10 idle err hold", err_s, h_err);
    chk("R10 idle word hold", fp_s, h_fp);
    // R10: outputs hold during a following search
    start_s = 1'b1;
    @(negedge clk);
    start_s = 1'b0;
    repeat (200) @(negedge clk);
    chk("R10 busy mid-search", busy_s, 1);
    chk("R10 mid err hold", err_s, h_err);
    chk("R10 mid p1 hold", p1_s, h_p1);
    wait_done_s();
    @(negedge clk);

    // R9: start while busy is ignored
    base_dn = dones_s;
    start_s = 1'b1; tgt_s = 32'd40000;
    @(negedge clk);
    start_s = 1'b0;
    repeat (40) @(negedge clk);
    start_s = 1'b1; tgt_s = 32'd200000;
    @(negedge clk);
    start_s = 1'b0;
    wait_done_s();
    model(40000, 1, 2, 17, 16, 6, 5, 3, 1, en, em1, em2, ep1, ep2, ee);
    chk("R9 err keeps first target", err_s, ee);
    chk("R9 word keeps first target", fp_s, (en << 16) | (em1 << 8) | em2);
    repeat (300) @(negedge clk);
    chk("R9 single done", dones_s - base_dn, 1);
    chk("R9 no restart", busy_s, 0);
    chk("R2 done one cycle", pulse_bad, 0);
  endtask

  task automatic full_seq();
    int en, em1, em2, ep1, ep2;
    longint unsigned ee;
    @(negedge clk);
    start_f = 1'b1; tgt_f = 32'd25175;
    @(negedge clk);
    start_f = 1'b0;
    for (int k = 0; k < 150000 && !done_f; k++) @(negedge clk);
    chk("R2 full done", done_f, 1);
    model(25175, 1, 4, 23, 16, 11, 5, 8, 1, en, em1, em2, ep1, ep2, ee);
    chk("R4 full error", err_f, ee);
    chk("R5 full word", fp_f, (en << 16) | (em1 << 8) | em2);
    chk("R5 full p1", p1_f, ep1);
    chk("R3 full p2", p2_f, ep2);
    chk("R8 full onehot", oh_f, 1 << (ep1 - 1));
    chk("R6 full found", found_f, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy_s, 0);
    chk("R1 done", done_s, 0);
    chk("R1 found", found_s, 0);
    chk("R1 err", err_s, 0);
    chk("R1 word", fp_s, 0);
    chk("R1 onehot", oh_s, 0);
    chk("R1 p2", p2_s, 0);
    fork
      small_seq();
      full_seq();
    join
    report();
  end

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule